// File: doc/BRIEF.md
# Register File and Arithmetic Unit with Flag Register

This block holds the sixteen 8-bit general registers and the 12-bit index register of a small byte-oriented processor. It carries out the data instructions of that processor. Each instruction is a 16-bit opcode, and one instruction runs on each clock in which the execute strobe is high. The instructions cover immediate loads, immediate add, register copy, bitwise logic, add and subtract with a flag, single-bit shifts, index loads and a masked pseudo-random byte.

Register 15 serves two roles. It is an ordinary register, and it is also where arithmetic instructions leave their status bit. Three combinational read ports expose the registers. Two of them are addressed by the register fields of the opcode currently on the input, and the third always shows register 0. A separate flow-control unit can use these ports for compares, computed jumps and stores. Program counter, memory access and timers live outside this block.

Top module: `vreg_unit`

## Requirements
- R1: After reset, all sixteen general registers and the index register read zero.
- R2: Opcode 0x6XKK loads byte KK into register X. Opcode 0x8XY0 copies register Y into register X. Neither changes register 15 unless X is 15.
- R3: Opcode 0xANNN loads the 12-bit value NNN into the index register. No other opcode changes the index register.
- R4: Opcode 0x7XKK adds KK to register X and keeps the low 8 bits (0x80 + 0xAB gives 0x2B). It leaves register 15 unchanged when X is not 15.
- R5: Opcode 0x8XY4 writes (X + Y) mod 256 to register X. It sets register 15 to exactly 1 on carry out and to exactly 0 otherwise, whatever register 15 held before.
- R6: Opcode 0x8XY5 writes (X - Y) mod 256 to register X. It sets register 15 to 1 when X >= Y and to 0 when a borrow occurs.
- R7: Opcode 0x8XY7 writes (Y - X) mod 256 to register X. It sets register 15 to 1 when Y >= X and to 0 otherwise.
- R8: Opcode 0x8XY6 shifts register X right by one bit and puts the old bit 0 into register 15. Opcode 0x8XYE shifts register X left by one bit and puts the old bit 7 into register 15.
- R9: Opcodes 0x8XY1, 0x8XY2 and 0x8XY3 write X OR Y, X AND Y and X XOR Y into register X. They leave register 15 unchanged when X is not 15.
- R10: Opcode 0xCXKK writes a pseudo-random byte ANDed with KK into register X. The byte comes from an 8-bit maximal-length LFSR that steps on every clock and starts from a nonzero seed, so the byte is never zero and differs on consecutive clocks.
- R11: When an instruction that sets the flag has destination X = 15, register 15 ends up holding the flag value, not the arithmetic result.
- R12: With the execute strobe low, no register changes. With the strobe high, an opcode outside the listed set (for example 0x1NNN, or 0x8XY8) changes no register.
- R13: The read port vx_o shows the register addressed by opcode bits 11:8, and vy_o shows the register addressed by bits 7:4. Both follow the opcode input without a clock. The port v0_o always shows register 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| exec_i | input | 1 | Execute strobe: run opcode_i on this clock edge |
| opcode_i | input | 16 | Instruction word; also addresses the read ports |
| vx_o | output | 8 | Register selected by opcode bits 11:8 |
| vy_o | output | 8 | Register selected by opcode bits 7:4 |
| v0_o | output | 8 | Register 0 |
| index_o | output | 12 | Index register |

## Verification
Add and both subtractions are each run with one operand pair that produces a carry or borrow and one that does not. The flag register is preloaded with the value opposite to the expected flag, so a flag that is only ever set, or only ever cleared, shows up as an error. Subtraction with equal operands separates a "greater or equal" comparison from a strict "greater than" comparison. Shifts use operands whose outgoing bit is 1 in one case and 0 in another, and logic and immediate-add run with a nonzero value parked in register 15 to show the flag is left alone. Instructions whose destination is register 15 separate flag-wins ordering from result-wins ordering.

// File: rtl/vreg_pkg.sv
package vreg_pkg;

    localparam int unsigned DATA_W   = 8;
    localparam int unsigned IDX_W    = 12;
    localparam int unsigned OPC_W    = 16;
    localparam int unsigned NUM_REGS = 16;
    localparam int unsigned SEL_W    = $clog2(NUM_REGS);
    localparam int unsigned FLAG_REG = NUM_REGS - 1;

    typedef enum logic [3:0] {
        OP_NONE,
        OP_LDI,
        OP_ADDI,
        OP_LDIDX,
        OP_MOV,
        OP_OR,
        OP_AND,
        OP_XOR,
        OP_ADD,
        OP_SUB,
        OP_SHR,
        OP_RSUB,
        OP_SHL,
        OP_RAND
    } op_e;

    typedef struct packed {
        op_e               op;
        logic [SEL_W-1:0]  x;
        logic [SEL_W-1:0]  y;
        logic [DATA_W-1:0] kk;
        logic [IDX_W-1:0]  nnn;
    } dec_t;

endpackage

// File: rtl/vreg_decode.sv
module vreg_decode
    import vreg_pkg::*;
(
    input  logic [OPC_W-1:0] opcode_i,
    output dec_t             dec_o
);

    logic [3:0] major;
    logic [3:0] minor;

    assign major = opcode_i[15:12];
    assign minor = opcode_i[3:0];

    always_comb begin
        dec_o.x   = opcode_i[11:8];
        dec_o.y   = opcode_i[7:4];
        dec_o.kk  = opcode_i[7:0];
        dec_o.nnn = opcode_i[IDX_W-1:0];
        dec_o.op  = OP_NONE;
        unique case (major)
            4'h6: dec_o.op = OP_LDI;
            4'h7: dec_o.op = OP_ADDI;
            4'hA: dec_o.op = OP_LDIDX;
            4'hC: dec_o.op = OP_RAND;
            4'h8: begin
                unique case (minor)
                    4'h0:    dec_o.op = OP_MOV;
                    4'h1:    dec_o.op = OP_OR;
                    4'h2:    dec_o.op = OP_AND;
                    4'h3:    dec_o.op = OP_XOR;
                    4'h4:    dec_o.op = OP_ADD;
                    4'h5:    dec_o.op = OP_SUB;
                    4'h6:    dec_o.op = OP_SHR;
                    4'h7:    dec_o.op = OP_RSUB;
                    4'hE:    dec_o.op = OP_SHL;
                    default: dec_o.op = OP_NONE;
                endcase
            end
            default: dec_o.op = OP_NONE;
        endcase
    end

endmodule

// File: rtl/vreg_lfsr.sv
module vreg_lfsr
    import vreg_pkg::*;
#(
    parameter int unsigned  W    = DATA_W,
    parameter logic [W-1:0] TAPS = 8'hB8,
    parameter logic [W-1:0] SEED = 8'hA5
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] rnd_o
);

    logic [W-1:0] lfsr_d, lfsr_q;
    logic         feedback;

    always_comb begin
        feedback = ^(lfsr_q & TAPS);
        lfsr_d   = {lfsr_q[W-2:0], feedback};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lfsr_q <= SEED;
        else        lfsr_q <= lfsr_d;
    end

    assign rnd_o = lfsr_q;

    AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_q != '0); // R10

    AST_LFSR_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> lfsr_q != $past(lfsr_q)); // R10

endmodule

// File: rtl/vreg_alu.sv
module vreg_alu
    import vreg_pkg::*;
(
    input  op_e               op_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic [DATA_W-1:0] kk_i,
    input  logic [DATA_W-1:0] rnd_i,
    output logic [DATA_W-1:0] res_o,
    output logic              res_we_o,
    output logic              flag_o,
    output logic              flag_we_o
);

    logic [DATA_W:0] sum_w;
    logic [DATA_W:0] diff_ab;
    logic [DATA_W:0] diff_ba;

    always_comb begin
        sum_w   = {1'b0, a_i} + {1'b0, b_i};
        diff_ab = {1'b0, a_i} - {1'b0, b_i};
        diff_ba = {1'b0, b_i} - {1'b0, a_i};

        res_o     = '0;
        res_we_o  = 1'b0;
        flag_o    = 1'b0;
        flag_we_o = 1'b0;

        unique case (op_i)
            OP_LDI: begin
                res_o    = kk_i;
                res_we_o = 1'b1;
            end
            OP_ADDI: begin
                res_o    = a_i + kk_i;
                res_we_o = 1'b1;
            end
            OP_MOV: begin
                res_o    = b_i;
                res_we_o = 1'b1;
            end
            OP_OR: begin
                res_o    = a_i | b_i;
                res_we_o = 1'b1;
            end
            OP_AND: begin
                res_o    = a_i & b_i;
                res_we_o = 1'b1;
            end
            OP_XOR: begin
                res_o    = a_i ^ b_i;
                res_we_o = 1'b1;
            end
            OP_ADD: begin
                res_o     = sum_w[DATA_W-1:0];
                res_we_o  = 1'b1;
                flag_o    = sum_w[DATA_W];
                flag_we_o = 1'b1;
            end
            OP_SUB: begin
                res_o     = diff_ab[DATA_W-1:0];
                res_we_o  = 1'b1;
                flag_o    = ~diff_ab[DATA_W];
                flag_we_o = 1'b1;
            end
            OP_RSUB: begin
                res_o     = diff_ba[DATA_W-1:0];
                res_we_o  = 1'b1;
                flag_o    = ~diff_ba[DATA_W];
                flag_we_o = 1'b1;
            end
            OP_SHR: begin
                res_o     = {1'b0, a_i[DATA_W-1:1]};
                res_we_o  = 1'b1;
                flag_o    = a_i[0];
                flag_we_o = 1'b1;
            end
            OP_SHL: begin
                res_o     = {a_i[DATA_W-2:0], 1'b0};
                res_we_o  = 1'b1;
                flag_o    = a_i[DATA_W-1];
                flag_we_o = 1'b1;
            end
            OP_RAND: begin
                res_o    = rnd_i & kk_i;
                res_we_o = 1'b1;
            end
            default: begin
                res_o     = '0;
                res_we_o  = 1'b0;
                flag_o    = 1'b0;
                flag_we_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/vreg_unit.sv
module vreg_unit
    import vreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exec_i,
    input  logic [15:0]       opcode_i,
    output logic [7:0]        vx_o,
    output logic [7:0]        vy_o,
    output logic [7:0]        v0_o,
    output logic [11:0]       index_o
);

    typedef struct packed {
        logic [NUM_REGS-1:0][DATA_W-1:0] regs;
        logic [IDX_W-1:0]                idx;
    } state_t;

    state_t            st_d, st_q;
    dec_t              dec;
    logic [DATA_W-1:0] rnd;
    logic [DATA_W-1:0] alu_res;
    logic              alu_res_we;
    logic              alu_flag;
    logic              alu_flag_we;

    vreg_decode u_decode (
        .opcode_i (opcode_i),
        .dec_o    (dec)
    );

    vreg_lfsr u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .rnd_o (rnd)
    );

    assign vx_o    = st_q.regs[dec.x];
    assign vy_o    = st_q.regs[dec.y];
    assign v0_o    = st_q.regs[0];
    assign index_o = st_q.idx;

    vreg_alu u_alu (
        .op_i      (dec.op),
        .a_i       (vx_o),
        .b_i       (vy_o),
        .kk_i      (dec.kk),
        .rnd_i     (rnd),
        .res_o     (alu_res),
        .res_we_o  (alu_res_we),
        .flag_o    (alu_flag),
        .flag_we_o (alu_flag_we)
    );

    // Next state: result first, flag afterwards so the flag wins on x = 15.
    always_comb begin
        st_d = st_q;
        if (exec_i) begin
            if (dec.op == OP_LDIDX) st_d.idx = dec.nnn;
            if (alu_res_we)         st_d.regs[dec.x] = alu_res;
            if (alu_flag_we)        st_d.regs[FLAG_REG] = {{(DATA_W-1){1'b0}}, alu_flag};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_i |=> $stable(st_q)); // R12

    AST_IDX_ONLY_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !(exec_i && opcode_i[15:12] == 4'hA) |=> $stable(index_o)); // R3

    AST_FLAG_BINARY: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && alu_flag_we) |=> st_q.regs[FLAG_REG][DATA_W-1:1] == '0); // R5

    AST_SHIFT_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && opcode_i[15:12] == 4'h8 && opcode_i[3:0] == 4'h6)
        |=> st_q.regs[FLAG_REG] == {7'b0, $past(vx_o[0])}); // R8

    AST_ADDI_KEEP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && opcode_i[15:12] == 4'h7 && opcode_i[11:8] != 4'hF)
        |=> $stable(st_q.regs[FLAG_REG])); // R4

    AST_V0_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && opcode_i[15:12] == 4'h6 && opcode_i[11:8] == 4'h0)
        |=> v0_o == $past(opcode_i[7:0])); // R13

endmodule

// File: tb/vreg_unit_test.sv
`timescale 1ns/1ps
module vreg_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exec_i = 1'b0;
    logic [15:0] opcode_i = 16'h0000;
    logic [7:0]  vx_o, vy_o, v0_o;
    logic [11:0] index_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    vreg_unit uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .exec_i   (exec_i),
        .opcode_i (opcode_i),
        .vx_o     (vx_o),
        .vy_o     (vy_o),
        .v0_o     (v0_o),
        .index_o  (index_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic run(input logic [15:0] op);
        @(negedge clk);
        opcode_i = op;
        exec_i   = 1'b1;
        @(negedge clk);
        exec_i   = 1'b0;
    endtask

    task automatic setr(input logic [3:0] r, input logic [7:0] v);
        run({4'h6, r, v});
    endtask

    task automatic getr(input logic [3:0] r, output logic [7:0] v);
        opcode_i = {4'h0, r, 8'h00};
        #0.5;
        v = vx_o;
    endtask

    task automatic expect_reg(input string req, input logic [3:0] r, input logic [7:0] e);
        logic [7:0] v;
        getr(r, v);
        check(req, int'(v), int'(e));
    endtask

    task automatic t_reset();
        @(negedge clk);
        for (int r = 0; r < 16; r++) expect_reg("R1 reset reg", 4'(r), 8'h00);
        check("R1 reset index", int'(index_o), 0);
    endtask

    task automatic t_load_copy();
        setr(4'h3, 8'h42);
        expect_reg("R2 load", 4'h3, 8'h42);
        setr(4'hF, 8'h07);
        setr(4'h1, 8'h23);
        run(16'h8010);
        expect_reg("R2 copy", 4'h0, 8'h23);
        expect_reg("R2 flag kept", 4'hF, 8'h07);
        check("R13 v0 port", int'(v0_o), 8'h23);
    endtask

    task automatic t_index();
        run(16'hAABC);
        check("R3 index load", int'(index_o), 12'hABC);
        setr(4'h2, 8'h11);
        check("R3 index kept", int'(index_o), 12'hABC);
    endtask

    task automatic t_addi();
        setr(4'hF, 8'h01);
        setr(4'hE, 8'h80);
        run(16'h7EAB);
        expect_reg("R4 add imm wrap", 4'hE, 8'h2B);
        expect_reg("R4 flag kept", 4'hF, 8'h01);
    endtask

    task automatic t_add();
        setr(4'hF, 8'h00); setr(4'h0, 8'hFF); setr(4'h1, 8'h50);
        run(16'h8014);
        expect_reg("R5 add carry sum", 4'h0, 8'h4F);
        expect_reg("R5 add carry flag", 4'hF, 8'h01);
        setr(4'hF, 8'h01); setr(4'h0, 8'h30); setr(4'h1, 8'h45);
        run(16'h8014);
        expect_reg("R5 add sum", 4'h0, 8'h75);
        expect_reg("R5 add no carry flag", 4'hF, 8'h00);
    endtask

    task automatic t_sub();
        setr(4'hF, 8'h00); setr(4'h0, 8'h45); setr(4'h1, 8'h30);
        run(16'h8015);
        expect_reg("R6 sub diff", 4'h0, 8'h15);
        expect_reg("R6 sub no borrow flag", 4'hF, 8'h01);
        setr(4'hF, 8'h01); setr(4'h0, 8'h30); setr(4'h1, 8'h45);
        run(16'h8015);
        expect_reg("R6 sub wrap", 4'h0, 8'hEB);
        expect_reg("R6 sub borrow flag", 4'hF, 8'h00);
        setr(4'hF, 8'h00); setr(4'h0, 8'h20); setr(4'h1, 8'h20);
        run(16'h8015);
        expect_reg("R6 sub equal", 4'h0, 8'h00);
        expect_reg("R6 sub equal flag", 4'hF, 8'h01);
    endtask

    task automatic t_rsub();
        setr(4'hF, 8'h00); setr(4'h0, 8'h1F); setr(4'h1, 8'h8A);
        run(16'h8017);
        expect_reg("R7 rsub diff", 4'h0, 8'h6B);
        expect_reg("R7 rsub no borrow flag", 4'hF, 8'h01);
        setr(4'hF, 8'h01); setr(4'h0, 8'h8A); setr(4'h1, 8'h1F);
        run(16'h8017);
        expect_reg("R7 rsub wrap", 4'h0, 8'h95);
        expect_reg("R7 rsub borrow flag", 4'hF, 8'h00);
    endtask

    task automatic t_shift();
        setr(4'hF, 8'h00); setr(4'h0, 8'h8F);
        run(16'h8016);
        expect_reg("R8 shr value", 4'h0, 8'h47);
        expect_reg("R8 shr flag", 4'hF, 8'h01);
        setr(4'hF, 8'h00); setr(4'h0, 8'hD1);
        run(16'h801E);
        expect_reg("R8 shl value", 4'h0, 8'hA2);
        expect_reg("R8 shl flag", 4'hF, 8'h01);
        setr(4'hF, 8'h01); setr(4'h0, 8'h40);
        run(16'h801E);
        expect_reg("R8 shl value zero out", 4'h0, 8'h80);
        expect_reg("R8 shl flag zero", 4'hF, 8'h00);
    endtask

    task automatic t_logic();
        setr(4'hF, 8'h05);
        setr(4'h0, 8'h12); setr(4'h1, 8'h23); run(16'h8011);
        expect_reg("R9 or", 4'h0, 8'h33);
        setr(4'h0, 8'h12); run(16'h8012);
        expect_reg("R9 and", 4'h0, 8'h02);
        setr(4'h0, 8'h12); run(16'h8013);
        expect_reg("R9 xor", 4'h0, 8'h31);
        expect_reg("R9 flag kept", 4'hF, 8'h05);
    endtask

    task automatic t_rand();
        logic [7:0] a, b;
        setr(4'h8, 8'h77);
        run(16'hC800);
        expect_reg("R10 rand mask zero", 4'h8, 8'h00);
        run(16'hC80F);
        getr(4'h8, a);
        check("R10 rand mask high nibble", int'(a & 8'hF0), 0);
        run(16'hC8FF);
        getr(4'h8, a);
        checks++;
        if (a == 8'h00) begin
            errors++;
            $display("FAIL R10 rand nonzero: actual=0x%0h expected=nonzero", a);
        end
        @(negedge clk);
        opcode_i = 16'hC9FF; exec_i = 1'b1;
        @(negedge clk);
        opcode_i = 16'hCAFF;
        @(negedge clk);
        exec_i = 1'b0;
        getr(4'h9, a);
        getr(4'hA, b);
        checks++;
        if (a == b) begin
            errors++;
            $display("FAIL R10 rand steps: actual=0x%0h expected!=0x%0h", b, a);
        end
    endtask

    task automatic t_flag_dest();
        setr(4'hF, 8'hF0); setr(4'h1, 8'h20);
        run(16'h8F14);
        expect_reg("R11 add into VF", 4'hF, 8'h01);
        setr(4'hF, 8'h02);
        run(16'h8F06);
        expect_reg("R11 shr into VF", 4'hF, 8'h00);
        setr(4'hF, 8'h10); setr(4'h1, 8'h20);
        run(16'h8F15);
        expect_reg("R11 sub into VF", 4'hF, 8'h00);
    endtask

    task automatic t_ignore();
        setr(4'h5, 8'h3C);
        setr(4'h1, 8'h99);
        @(negedge clk);
        opcode_i = 16'h65AA; exec_i = 1'b0;
        @(negedge clk);
        expect_reg("R12 strobe low", 4'h5, 8'h3C);
        run(16'h8158);
        expect_reg("R12 unsupported 8xy8", 4'h1, 8'h99);
        run(16'h1234);
        check("R12 jump ignored index", int'(index_o), 12'hABC);
        expect_reg("R12 jump ignored reg", 4'h2, 8'h11);
    endtask

    task automatic t_ports();
        setr(4'h6, 8'h5D);
        setr(4'h7, 8'hC3);
        opcode_i = 16'h0670;
        #0.5;
        check("R13 vx port", int'(vx_o), 8'h5D);
        check("R13 vy port", int'(vy_o), 8'hC3);
    endtask

    initial begin
        #1000000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_load_copy();
        t_index();
        t_addi();
        t_add();
        t_sub();
        t_rsub();
        t_shift();
        t_logic();
        t_rand();
        t_flag_dest();
        t_ignore();
        t_ports();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule